// File: doc/BRIEF.md
# Linked Frame Descriptor Fetch Engine

This block is the memory-reading front end of a display controller. Software builds a chain of frame descriptors in memory. Each descriptor is four 32-bit words. The engine is given the address of the first descriptor and a start pulse. It reads that descriptor and keeps the frame's source address, frame identifier and command flags. It then reads the frame's pixel words in bursts whose length is selected by a two-bit input. Each pixel word is forwarded downstream as it arrives.

When the last pixel word of a frame has arrived, the engine follows the descriptor's link word to the next descriptor and carries on without software. A descriptor that links to itself repeats one frame forever. Start-of-frame and end-of-frame interrupt pulses are requested per frame by bits of the descriptor's command word. A stop request lets the current frame finish, including every burst, and then parks the engine. The memory port has one outstanding read: a request with address and word count, held until accepted, followed by in-order response beats.

Top module: `frame_desc_dma`

## Requirements
- R1: After reset, `busy`, `rd_req`, `pix_valid`, `sof_irq` and `eof_irq` are low, and `cur_src`, `cur_fid` and `pal_flag` are zero.
- R2: A `go` pulse while idle makes the engine request 4 words at `head_addr`. A `go` pulse while busy is ignored, and no read is ever issued at the address it carried.
- R3: The response words of a descriptor are taken in order as link address, source address, frame ID, command. `cur_src`, `cur_fid` and `pal_flag` (command bit 12) change together, in the cycle after the fourth word arrives.
- R4: Pixel reads start at the source address and advance by 4 bytes per word. `burst_sel` picks the burst size: 0 gives 4 words, 1 gives 8 words, 2 and 3 give 16 words.
- R5: Each pixel request asks for the smaller of the burst size and the words still due. The words of a frame add up to `frame_words`, which is sampled when the descriptor completes. A value of 0 issues no pixel read.
- R6: In the pixel phase, every response beat appears on `pix_valid`/`pix_data` in the same cycle. Descriptor beats never do.
- R7: `sof_irq` pulses for exactly one cycle, in the cycle after a descriptor's fourth word arrives, when command bit 15 is set.
- R8: `eof_irq` pulses for exactly one cycle, in the cycle after a frame's last pixel word arrives, when command bit 16 is set. For a frame of 0 words it pulses in the cycle after the fourth descriptor word.
- R9: At the end of each frame the next descriptor is read from the link address. A self-linked descriptor is fetched again and again.
- R10: A `stop_req` pulse while busy lets the current frame finish all its reads, then drops `busy`, and no further request follows. A `stop_req` pulse while idle has no effect on the next start.
- R11: Only one read is outstanding. `rd_req`, `rd_addr` and `rd_len` hold until `rd_ready`, and no new request is raised while response beats are still owed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go | input | 1 | Start pulse, taken only while idle |
| head_addr | input | 32 | Address of the first descriptor |
| stop_req | input | 1 | Stop after the current frame |
| burst_sel | input | 2 | Burst size select |
| frame_words | input | 16 | Pixel words per frame |
| rd_req | output | 1 | Read request valid |
| rd_addr | output | 32 | Read byte address |
| rd_len | output | 5 | Words requested |
| rd_ready | input | 1 | Request accepted this cycle |
| rsp_valid | input | 1 | Response beat valid |
| rsp_data | input | 32 | Response beat data |
| pix_valid | output | 1 | Pixel word valid |
| pix_data | output | 32 | Pixel word |
| cur_src | output | 32 | Source address of the current frame |
| cur_fid | output | 32 | Frame ID of the current frame |
| pal_flag | output | 1 | Current frame carries a palette |
| sof_irq | output | 1 | Start-of-frame interrupt pulse |
| eof_irq | output | 1 | End-of-frame interrupt pulse |
| busy | output | 1 | Engine is running |

## Verification
The hardest cases to reach are the ones where the frame boundary coincides with other events. A stop can land in the same cycle as the last pixel beat. A frame can need a shortened final burst. A frame can have zero words, so the descriptor fetch runs straight into the next descriptor fetch. The stimulus reaches these cases with frame lengths that do not divide by the burst size (10, 20, 37) and a zero-length chain. It also randomises request acceptance and response gaps, so stop pulses and stray start pulses fall at many different points of a frame. Self-linked and two-descriptor chains are run long enough to wrap several times.

// File: rtl/fdf_pkg.sv
package fdf_pkg;
  localparam int LEN_W      = 5;
  localparam int DESC_WORDS = 4;
  localparam int CMD_PAL_BIT = 12;
  localparam int CMD_SOF_BIT = 15;
  localparam int CMD_EOF_BIT = 16;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_DREQ = 3'd1,
    ST_DRSP = 3'd2,
    ST_PREQ = 3'd3,
    ST_PRSP = 3'd4
  } fdf_state_e;

  typedef struct packed {
    logic pal;
    logic eof;
  } cmd_flags_t;

  function automatic logic [LEN_W-1:0] burst_words(input logic [1:0] sel);
    case (sel)
      2'd0:    burst_words = LEN_W'(4);
      2'd1:    burst_words = LEN_W'(8);
      default: burst_words = LEN_W'(16);
    endcase
  endfunction
endpackage

// File: rtl/fdf_rst_sync.sv
module fdf_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/fdf_desc_regs.sv
module fdf_desc_regs
  import fdf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [1:0]        cap_idx,
  input  logic [DATA_W-1:0] cap_data,
  output logic [DATA_W-1:0] link_ptr,
  output logic [DATA_W-1:0] stage_src,
  output logic [DATA_W-1:0] cur_src,
  output logic [DATA_W-1:0] cur_fid,
  output cmd_flags_t        cur_flags
);
  localparam int STAGED = DESC_WORDS - 1;

  logic [DATA_W-1:0] stage_q [STAGED];
  logic              commit;

  assign commit = cap_en && (cap_idx == 2'(STAGED));

  for (genvar w = 0; w < STAGED; w++) begin : g_stage
    logic              ld;
    logic [DATA_W-1:0] stage_d;
    assign ld = cap_en && (cap_idx == 2'(w));
    always_comb begin
      stage_d = stage_q[w];
      if (ld) stage_d = cap_data;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[w] <= '0;
      else        stage_q[w] <= stage_d;
    end
  end

  logic [DATA_W-1:0] src_d, fid_d;
  cmd_flags_t        flags_d;

  always_comb begin
    src_d   = cur_src;
    fid_d   = cur_fid;
    flags_d = cur_flags;
    if (commit) begin
      src_d       = stage_q[1];
      fid_d       = stage_q[2];
      flags_d.pal = cap_data[CMD_PAL_BIT];
      flags_d.eof = cap_data[CMD_EOF_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_src   <= '0;
      cur_fid   <= '0;
      cur_flags <= '0;
    end else begin
      cur_src   <= src_d;
      cur_fid   <= fid_d;
      cur_flags <= flags_d;
    end
  end

  assign link_ptr  = stage_q[0];
  assign stage_src = stage_q[1];

  // R3: the visible frame fields only move on the commit of a fourth word
  a_r3_fields_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(cur_src) && $stable(cur_fid));
endmodule

// File: rtl/fdf_burst_calc.sv
module fdf_burst_calc
  import fdf_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int FLEN_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        burst_sel,
  input  logic              frame_load,
  input  logic [ADDR_W-1:0] load_src,
  input  logic [FLEN_W-1:0] frame_words,
  input  logic              take,
  output logic [ADDR_W-1:0] fetch_ptr,
  output logic [LEN_W-1:0]  req_len,
  output logic              rem_zero
);
  logic [FLEN_W-1:0] rem_q, rem_d;
  logic [ADDR_W-1:0] ptr_d;
  logic [LEN_W-1:0]  burst;

  assign burst    = burst_words(burst_sel);
  assign req_len  = (rem_q < FLEN_W'(burst)) ? rem_q[LEN_W-1:0] : burst;
  assign rem_zero = (rem_q == '0);

  always_comb begin
    ptr_d = fetch_ptr;
    rem_d = rem_q;
    if (frame_load) begin
      ptr_d = load_src;
      rem_d = frame_words;
    end else if (take) begin
      ptr_d = fetch_ptr + (ADDR_W'(req_len) << 2);
      rem_d = rem_q - FLEN_W'(req_len);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fetch_ptr <= '0;
      rem_q     <= '0;
    end else begin
      fetch_ptr <= ptr_d;
      rem_q     <= rem_d;
    end
  end

  // R5: a pixel burst never asks for more than is still due, nor for nothing
  a_r5_len_fits: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (req_len != '0) && (FLEN_W'(req_len) <= rem_q));
  // R4: the burst ceiling is never exceeded
  a_r4_len_cap: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> req_len <= LEN_W'(16));
endmodule

// File: rtl/fdf_ctrl.sv
module fdf_ctrl
  import fdf_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [ADDR_W-1:0] head_addr,
  input  logic              stop_req,
  input  logic              rd_ready,
  input  logic              rsp_valid,
  input  logic              rsp_sof,
  input  logic              rsp_eof,
  input  logic              fw_zero,
  input  logic [ADDR_W-1:0] link_ptr,
  input  logic              cur_eof,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              rem_zero,
  output logic              cap_en,
  output logic [1:0]        cap_idx,
  output logic              frame_load,
  output logic              take,
  output logic              req_desc,
  output logic              req_pix,
  output logic              in_pix,
  output logic              busy,
  output logic [ADDR_W-1:0] desc_ptr,
  output logic              sof_irq,
  output logic              eof_irq
);
  fdf_state_e       st_q, st_d;
  logic [ADDR_W-1:0] desc_d;
  logic [1:0]       idx_q, idx_d;
  logic [LEN_W-1:0] beats_q, beats_d;
  logic             pend_q, pend_d;
  logic             sof_d, eof_d;
  logic             frame_end, end_eof;

  always_comb begin
    st_d       = st_q;
    desc_d     = desc_ptr;
    idx_d      = idx_q;
    beats_d    = beats_q;
    pend_d     = pend_q;
    sof_d      = 1'b0;
    eof_d      = 1'b0;
    cap_en     = 1'b0;
    frame_load = 1'b0;
    take       = 1'b0;
    frame_end  = 1'b0;
    end_eof    = 1'b0;
    if (stop_req && (st_q != ST_IDLE)) pend_d = 1'b1;
    case (st_q)
      ST_IDLE: if (go) begin
        desc_d = head_addr;
        st_d   = ST_DREQ;
      end
      ST_DREQ: if (rd_ready) begin
        idx_d = '0;
        st_d  = ST_DRSP;
      end
      ST_DRSP: if (rsp_valid) begin
        cap_en = 1'b1;
        idx_d  = idx_q + 2'd1;
        if (idx_q == 2'(DESC_WORDS - 1)) begin
          frame_load = 1'b1;
          sof_d      = rsp_sof;
          if (fw_zero) begin
            frame_end = 1'b1;
            end_eof   = rsp_eof;
          end else begin
            st_d = ST_PREQ;
          end
        end
      end
      ST_PREQ: if (rd_ready) begin
        take    = 1'b1;
        beats_d = req_len;
        st_d    = ST_PRSP;
      end
      ST_PRSP: if (rsp_valid) begin
        beats_d = beats_q - LEN_W'(1);
        if (beats_q == LEN_W'(1)) begin
          if (rem_zero) begin
            frame_end = 1'b1;
            end_eof   = cur_eof;
          end else begin
            st_d = ST_PREQ;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
    if (frame_end) begin
      eof_d = end_eof;
      if (pend_d) begin
        st_d   = ST_IDLE;
        pend_d = 1'b0;
      end else begin
        st_d   = ST_DREQ;
        desc_d = link_ptr;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      desc_ptr <= '0;
      idx_q    <= '0;
      beats_q  <= '0;
      pend_q   <= 1'b0;
      sof_irq  <= 1'b0;
      eof_irq  <= 1'b0;
    end else begin
      st_q     <= st_d;
      desc_ptr <= desc_d;
      idx_q    <= idx_d;
      beats_q  <= beats_d;
      pend_q   <= pend_d;
      sof_irq  <= sof_d;
      eof_irq  <= eof_d;
    end
  end

  assign cap_idx  = idx_q;
  assign req_desc = (st_q == ST_DREQ);
  assign req_pix  = (st_q == ST_PREQ);
  assign in_pix   = (st_q == ST_PRSP);
  assign busy     = (st_q != ST_IDLE);

  // R11: an unaccepted request is still raised in the next cycle
  a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ((req_desc || req_pix) && !rd_ready) |=> (req_desc || req_pix));
  // R11: no request while pixel beats are still owed
  a_r11_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    (in_pix && beats_q > LEN_W'(1)) |-> !(req_desc || req_pix));
  // R7: start-of-frame pulse lasts one cycle
  a_r7_sof_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    sof_irq |=> !sof_irq);
  // R8: end-of-frame pulse lasts one cycle
  a_r8_eof_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    eof_irq |=> !eof_irq);
  // R10: once parked, the engine stays parked unless started
  a_r10_stay_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !go) |=> !busy);
endmodule

// File: rtl/frame_desc_dma.sv
module frame_desc_dma
  import fdf_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int FLEN_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [ADDR_W-1:0] head_addr,
  input  logic              stop_req,
  input  logic [1:0]        burst_sel,
  input  logic [FLEN_W-1:0] frame_words,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [LEN_W-1:0]  rd_len,
  input  logic              rd_ready,
  input  logic              rsp_valid,
  input  logic [DATA_W-1:0] rsp_data,
  output logic              pix_valid,
  output logic [DATA_W-1:0] pix_data,
  output logic [DATA_W-1:0] cur_src,
  output logic [DATA_W-1:0] cur_fid,
  output logic              pal_flag,
  output logic              sof_irq,
  output logic              eof_irq,
  output logic              busy
);
  logic              rstn_i;
  logic              cap_en, frame_load, take;
  logic [1:0]        cap_idx;
  logic              req_desc, req_pix, in_pix;
  logic [DATA_W-1:0] link_ptr, stage_src;
  cmd_flags_t        flags;
  logic [ADDR_W-1:0] desc_ptr, fetch_ptr;
  logic [LEN_W-1:0]  req_len;
  logic              rem_zero;

  fdf_rst_sync i_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rstn_i)
  );

  fdf_desc_regs #(.DATA_W(DATA_W)) i_desc (
    .clk       (clk),
    .rst_n     (rstn_i),
    .cap_en    (cap_en),
    .cap_idx   (cap_idx),
    .cap_data  (rsp_data),
    .link_ptr  (link_ptr),
    .stage_src (stage_src),
    .cur_src   (cur_src),
    .cur_fid   (cur_fid),
    .cur_flags (flags)
  );

  fdf_burst_calc #(.ADDR_W(ADDR_W), .FLEN_W(FLEN_W)) i_burst (
    .clk         (clk),
    .rst_n       (rstn_i),
    .burst_sel   (burst_sel),
    .frame_load  (frame_load),
    .load_src    (ADDR_W'(stage_src)),
    .frame_words (frame_words),
    .take        (take),
    .fetch_ptr   (fetch_ptr),
    .req_len     (req_len),
    .rem_zero    (rem_zero)
  );

  fdf_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk        (clk),
    .rst_n      (rstn_i),
    .go         (go),
    .head_addr  (head_addr),
    .stop_req   (stop_req),
    .rd_ready   (rd_ready),
    .rsp_valid  (rsp_valid),
    .rsp_sof    (rsp_data[CMD_SOF_BIT]),
    .rsp_eof    (rsp_data[CMD_EOF_BIT]),
    .fw_zero    (frame_words == '0),
    .link_ptr   (ADDR_W'(link_ptr)),
    .cur_eof    (flags.eof),
    .req_len    (req_len),
    .rem_zero   (rem_zero),
    .cap_en     (cap_en),
    .cap_idx    (cap_idx),
    .frame_load (frame_load),
    .take       (take),
    .req_desc   (req_desc),
    .req_pix    (req_pix),
    .in_pix     (in_pix),
    .busy       (busy),
    .desc_ptr   (desc_ptr),
    .sof_irq    (sof_irq),
    .eof_irq    (eof_irq)
  );

  assign rd_req    = req_desc || req_pix;
  assign rd_addr   = req_desc ? desc_ptr : fetch_ptr;
  assign rd_len    = req_desc ? LEN_W'(DESC_WORDS) : req_len;
  assign pix_valid = in_pix && rsp_valid;
  assign pix_data  = rsp_data;
  assign pal_flag  = flags.pal;

  // R11: a waiting request keeps its address and length
  a_r11_addr_hold: assert property (@(posedge clk) disable iff (!rstn_i)
    (rd_req && !rd_ready) |=> rd_req && $stable(rd_addr) && $stable(rd_len));
  // R10: an idle engine reads nothing and forwards nothing
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rstn_i)
    !busy |-> !rd_req && !pix_valid);
endmodule

// File: tb/test_frame_desc_dma.sv
module test_frame_desc_dma;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        go = 1'b0, stop_req = 1'b0;
  logic [31:0] head_addr = '0;
  logic [1:0]  burst_sel = '0;
  logic [15:0] frame_words = '0;
  logic        rd_req, rd_ready = 1'b0;
  logic [31:0] rd_addr;
  logic [4:0]  rd_len;
  logic        rsp_valid = 1'b0;
  logic [31:0] rsp_data = '0;
  logic        pix_valid, pal_flag, sof_irq, eof_irq, busy;
  logic [31:0] pix_data, cur_src, cur_fid;

  int n_tests = 0, n_fail = 0;
  logic [31:0] mem [int unsigned];
  logic [31:0] rq [$];

  // scenario counters
  int eof_seen = 0, sof_seen = 0, pix_seen = 0;
  int fetch_at_watch = 0;
  logic [31:0] watch_addr = 32'hFFFF_FFF0;

  frame_desc_dma i_frame_desc_dma (
    .clk(clk), .rst_n(rst_n), .go(go), .head_addr(head_addr), .stop_req(stop_req),
    .burst_sel(burst_sel), .frame_words(frame_words), .rd_req(rd_req),
    .rd_addr(rd_addr), .rd_len(rd_len), .rd_ready(rd_ready), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .pix_valid(pix_valid), .pix_data(pix_data),
    .cur_src(cur_src), .cur_fid(cur_fid), .pal_flag(pal_flag), .sof_irq(sof_irq),
    .eof_irq(eof_irq), .busy(busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] memrd(input logic [31:0] a);
    if (mem.exists(a)) return mem[a];
    return a ^ 32'h5A5A_0000;
  endfunction

  task automatic put_desc(input logic [31:0] at, input logic [31:0] lnk,
                          input logic [31:0] src, input logic [31:0] fid, input logic [31:0] cmd);
    mem[at] = lnk; mem[at+4] = src; mem[at+8] = fid; mem[at+12] = cmd;
  endtask

  // ---------------- behavioural reference model ----------------
  localparam int M_IDLE = 0, M_DREQ = 1, M_DRSP = 2, M_PREQ = 3, M_PRSP = 4;
  int          m_st = M_IDLE, m_idx = 0, m_rem = 0, m_beats = 0;
  logic [31:0] m_desc = '0, m_ptr = '0, m_link = '0, m_ssrc = '0, m_sfid = '0;
  logic [31:0] m_src = '0, m_fid = '0;
  bit          m_pal = 0, m_eofen = 0, m_sof = 0, m_eof = 0, m_pend = 0;

  function automatic int blen(input logic [1:0] s);
    return (s == 2'd0) ? 4 : (s == 2'd1) ? 8 : 16;
  endfunction
  function automatic int want(input logic [1:0] s, input int rem);
    return (rem < blen(s)) ? rem : blen(s);
  endfunction

  always @(posedge clk) begin
    bit ended, e, pend;
    ended = 0; e = 0;
    if (!rst_n) begin
      m_st = M_IDLE; m_pend = 0; m_sof = 0; m_eof = 0;
      m_src = '0; m_fid = '0; m_pal = 0; m_eofen = 0;
    end else begin
      pend = m_pend || (stop_req && m_st != M_IDLE);
      m_sof = 0; m_eof = 0;
      case (m_st)
        M_IDLE: if (go) begin m_desc = head_addr; m_st = M_DREQ; end
        M_DREQ: if (rd_ready) begin m_st = M_DRSP; m_idx = 0; end
        M_DRSP: if (rsp_valid) begin
          if (m_idx == 0) m_link = rsp_data;
          else if (m_idx == 1) m_ssrc = rsp_data;
          else if (m_idx == 2) m_sfid = rsp_data;
          else begin
            m_src = m_ssrc; m_fid = m_sfid; m_pal = rsp_data[12]; m_eofen = rsp_data[16];
            m_sof = rsp_data[15]; m_ptr = m_ssrc; m_rem = int'(frame_words);
            if (m_rem == 0) begin ended = 1; e = rsp_data[16]; end
            else m_st = M_PREQ;
          end
          m_idx++;
        end
        M_PREQ: if (rd_ready) begin
          m_beats = want(burst_sel, m_rem);
          m_ptr += 32'(4 * m_beats); m_rem -= m_beats; m_st = M_PRSP;
        end
        M_PRSP: if (rsp_valid) begin
          m_beats--;
          if (m_beats == 0) begin
            if (m_rem == 0) begin ended = 1; e = m_eofen; end
            else m_st = M_PREQ;
          end
        end
        default: ;
      endcase
      if (ended) begin
        m_eof = e;
        if (pend) begin m_st = M_IDLE; pend = 0; end
        else begin m_st = M_DREQ; m_desc = m_link; end
      end
      m_pend = pend;
    end
  end

  // ---------------- memory model and per-cycle comparison ----------------
  always @(negedge clk) begin
    if (!rst_n) begin
      rd_ready = 0; rsp_valid = 0; rq.delete();
    end else begin
      if (rq.size() > 0 && $urandom_range(3) != 0) begin
        rsp_valid = 1; rsp_data = memrd(rq.pop_front());
      end else begin
        rsp_valid = 0; rsp_data = 32'hDEAD_0000 | 32'($urandom_range(255));
      end
      rd_ready = ($urandom_range(3) != 0);
      if (rd_req && rd_ready) begin
        for (int i = 0; i < int'(rd_len); i++) rq.push_back(rd_addr + 32'(4*i));
        if (rd_addr == watch_addr && rd_len == 5'd4) fetch_at_watch++;
      end
      #1;
      begin
        bit ereq;
        ereq = (m_st == M_DREQ) || (m_st == M_PREQ);
        chk(busy == (m_st != M_IDLE), "R10 busy", 32'(busy), 32'(m_st != M_IDLE));
        chk(rd_req == ereq, "R11 rd_req", 32'(rd_req), 32'(ereq));
        if (rd_req && ereq) begin
          logic [31:0] ea; int el;
          ea = (m_st == M_DREQ) ? m_desc : m_ptr;
          el = (m_st == M_DREQ) ? 4 : want(burst_sel, m_rem);
          chk(rd_addr == ea, "R4 rd_addr", rd_addr, ea);
          chk(int'(rd_len) == el, "R5 rd_len", 32'(rd_len), 32'(el));
        end
        chk(pix_valid == ((m_st == M_PRSP) && rsp_valid), "R6 pix_valid",
            32'(pix_valid), 32'((m_st == M_PRSP) && rsp_valid));
        if (pix_valid) chk(pix_data == rsp_data, "R6 pix_data", pix_data, rsp_data);
        chk(cur_src == m_src, "R3 cur_src", cur_src, m_src);
        chk(cur_fid == m_fid, "R3 cur_fid", cur_fid, m_fid);
        chk(pal_flag == m_pal, "R3 pal_flag", 32'(pal_flag), 32'(m_pal));
        chk(sof_irq == m_sof, "R7 sof_irq", 32'(sof_irq), 32'(m_sof));
        chk(eof_irq == m_eof, "R8 eof_irq", 32'(eof_irq), 32'(m_eof));
        if (eof_irq) eof_seen++;
        if (sof_irq) sof_seen++;
        if (pix_valid) pix_seen++;
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic pulse_go(input logic [31:0] a);
    @(negedge clk); head_addr = a; go = 1;
    @(negedge clk); go = 0;
  endtask
  task automatic pulse_stop();
    @(negedge clk); stop_req = 1;
    @(negedge clk); stop_req = 0;
  endtask
  task automatic wait_idle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask
  task automatic idle_quiet(input int n);
    int reqs;
    reqs = 0;
    repeat (n) begin @(negedge clk); #2; if (rd_req || busy) reqs++; end
    chk(reqs == 0, "R10 quiet after stop", 32'(reqs), 32'd0);
  endtask

  initial begin
    put_desc(32'h100, 32'h110, 32'h8000, 32'h11, 32'h0001_9000);
    put_desc(32'h110, 32'h100, 32'h9000, 32'h22, 32'h0001_0000);
    put_desc(32'h200, 32'h200, 32'hA000, 32'h33, 32'h0000_0000);
    put_desc(32'h300, 32'h300, 32'hB000, 32'h44, 32'h0001_0000);
    put_desc(32'h400, 32'h400, 32'hC000, 32'h55, 32'h0000_9000);
    put_desc(32'h600, 32'h610, 32'hD000, 32'h66, 32'h0001_8000);
    put_desc(32'h610, 32'h600, 32'hE000, 32'h77, 32'h0000_0000);

    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    #2;
    // R1 reset state
    chk(!busy && !rd_req && !pix_valid, "R1 idle outputs", {busy, rd_req, pix_valid}, 0);
    chk(!sof_irq && !eof_irq, "R1 irqs low", {sof_irq, eof_irq}, 0);
    chk(cur_src == 0 && cur_fid == 0 && !pal_flag, "R1 frame fields", cur_src, 0);

    // Scenario 1: two-descriptor chain, 4-word bursts, 10-word frames
    burst_sel = 2'd0; frame_words = 16'd10;
    watch_addr = 32'h500; fetch_at_watch = 0; eof_seen = 0;
    @(negedge clk); head_addr = 32'h100; go = 1;
    @(negedge clk); go = 0; #2;
    chk(rd_req && rd_addr == 32'h100 && rd_len == 5'd4, "R2 first descriptor read", rd_addr, 32'h100);
    repeat (120) @(negedge clk);
    pulse_go(32'h500);
    repeat (200) @(negedge clk);
    pulse_stop();
    wait_idle();
    idle_quiet(40);
    chk(fetch_at_watch == 0, "R2 go while busy ignored", 32'(fetch_at_watch), 0);
    chk(eof_seen >= 2, "R8 eof pulses seen", 32'(eof_seen), 2);

    // Scenario 2: stop in idle, then self-linked descriptor, 8-word bursts
    burst_sel = 2'd1; frame_words = 16'd8;
    watch_addr = 32'h200; fetch_at_watch = 0; eof_seen = 0;
    pulse_stop();
    pulse_go(32'h200);
    repeat (400) @(negedge clk);
    chk(busy, "R10 idle stop has no effect", 32'(busy), 1);
    chk(fetch_at_watch >= 3, "R9 self-link refetched", 32'(fetch_at_watch), 3);
    chk(eof_seen == 0, "R8 eof disabled by command", 32'(eof_seen), 0);
    pulse_stop();
    wait_idle();
    idle_quiet(20);

    // Scenario 3: 16-word bursts, 20-word frame (short final burst)
    burst_sel = 2'd2; frame_words = 16'd20;
    pulse_go(32'h300);
    repeat (250) @(negedge clk);
    pulse_stop();
    wait_idle();

    // Scenario 4: select 3 behaves as 16, 37-word frame
    burst_sel = 2'd3; frame_words = 16'd37;
    sof_seen = 0;
    pulse_go(32'h400);
    repeat (300) @(negedge clk);
    chk(sof_seen >= 2, "R7 sof pulses seen", 32'(sof_seen), 2);
    pulse_stop();
    wait_idle();

    // Scenario 5: zero-length frames
    frame_words = 16'd0; pix_seen = 0; eof_seen = 0;
    pulse_go(32'h600);
    repeat (150) @(negedge clk);
    chk(pix_seen == 0, "R5 zero frame reads no pixels", 32'(pix_seen), 0);
    chk(eof_seen >= 2, "R8 zero frame eof", 32'(eof_seen), 2);
    pulse_stop();
    wait_idle();
    idle_quiet(20);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule